// File: doc/BRIEF.md
# Infrared Pulse-Symbol Capture Receiver

This block is the receive front end of a remote-control link. It watches a demodulated infrared or UHF input line. For every symbol it measures two things: how long the carrier was present (the mark), and how long the whole symbol lasted, counted from one rising edge to the next. It stores each pair in a small capture queue. Software derives the space time as the period minus the mark. The carrier itself and the protocol meaning of the symbols are handled elsewhere.

The input first passes through a two-flop synchroniser. An optional polarity flip follows, then a glitch filter with a programmable minimum width. Time is counted in sample ticks. A programmable integer divisor derives the tick from the system clock; a divisor of 10 on a 100 MHz clock gives 10 MHz sampling. If no new rising edge arrives within a programmable maximum period, the open symbol is closed with its period field set to all-ones. That entry marks the end of a pulse train.

Software uses a simple register bus. Each register has its own 4-bit index, and a read returns data combinationally in the same cycle. Software reads the period register first and then the mark register, and the mark read removes the entry from the queue. A level interrupt combines four sticky pending flags with a per-flag enable mask: data captured, end of train, queue overrun and queue full.

Top module: `ir_symcap`

## Requirements
- R1: With divisor 1, an input held high for H cycles and then low for L cycles before the next rise yields an entry whose mark is H and whose period is H+L ticks.
- R2: If no rising edge arrives and the elapsed count exceeds the maximum-period register (index 5), the open entry is pushed with period 16'hFFFF and its mark. A period equal to the maximum is still recorded as its count.
- R3: The divisor register (index 10, reset value 10) sets the tick as one per divisor system clocks. With divisor 4, a high time of 40 clocks and a period of 100 clocks read as 10 and 25.
- R4: When bit 0 of the polarity register (index 8) is 1, the input is inverted before timing, so low pulses on the pin are measured as marks.
- R5: With the noise register (index 7) set to N ≥ 1, any input level lasting fewer than N ticks is ignored. Levels lasting at least N ticks are timed with their durations unchanged.
- R6: While bit 0 of the control register (index 4) is 0, no entry is pushed.
- R7: The queue holds 8 entries. A push into a full queue with no pop in the same cycle is dropped and sets pending bit 2 (overrun). The status register (index 9) reads 8'hFF in bits 15:8 when the queue is not empty and the overrun flag in bit 2, with all other bits 0.
- R8: The period register (index 0) and the mark register (index 1) show the oldest entry. Only a read of the mark register removes that entry. An empty queue reads 0 from both.
- R9: The pending register (index 3) has four bits: bit 0 set on each push, bit 1 set when a pushed entry has period 16'hFFFF, bit 2 on overrun, bit 3 when a push fills the queue. Writing 1s to the clear register (index 6) clears the matching bits, and a new set wins in the same cycle. irq is 1 exactly when a pending bit is set whose bit in the enable register (index 2) is also set.
- R10: After reset, the control, polarity, noise, enable and pending registers read 0. The maximum period reads 16'h5000, the divisor reads 10, the status reads 0 and irq is 0.
- R11: A push and a mark-register pop in the same cycle on a full queue both take effect, without overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_in | input | 1 | Demodulated receiver line, asynchronous |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 4 | Register index |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| irq | output | 1 | Level interrupt request |

## Verification
The queue has one pair of functions that can land in the same cycle: the edge timer pushes an entry while software pops the head with a mark-register read. The bench fills the queue with eight entries of distinct marks. It then raises the input and asserts the mark read exactly five clocks later, which is the cycle the push reaches the queue. The overlap is judged correct when no overrun is flagged and draining the queue returns the seven older entries followed by the new one.

// File: rtl/ir_symcap_pkg.sv
package ir_symcap_pkg;

    localparam int SYM_W = 16;

    typedef struct packed {
        logic [SYM_W-1:0] mark;
        logic [SYM_W-1:0] period;
    } sym_t;

    typedef enum logic [3:0] {
        REG_PERIOD = 4'd0,
        REG_MARK   = 4'd1,
        REG_IEN    = 4'd2,
        REG_PEND   = 4'd3,
        REG_CTRL   = 4'd4,
        REG_MAXPER = 4'd5,
        REG_CLEAR  = 4'd6,
        REG_NOISE  = 4'd7,
        REG_POL    = 4'd8,
        REG_STATUS = 4'd9,
        REG_DIV    = 4'd10
    } reg_e;

    localparam int EV_DATA = 0;
    localparam int EV_LAST = 1;
    localparam int EV_OVR  = 2;
    localparam int EV_FULL = 3;

    localparam logic [SYM_W-1:0] END_CODE = '1;

    function automatic logic [SYM_W-1:0] sat_count(input logic [SYM_W:0] v);
        return v[SYM_W] ? END_CODE : v[SYM_W-1:0];
    endfunction

endpackage

// File: rtl/ir_symcap_tick.sv
module ir_symcap_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim  = (div == '0) ? '0 : div - 1'b1;
    assign tick = (cnt >= lim);

    always_ff @(posedge clk) begin
        if (rst)       cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/ir_symcap_front.sv
module ir_symcap_front #(
    parameter int NOISE_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               ir_in,
    input  logic               pol,
    input  logic [NOISE_W-1:0] noise,
    output logic               filt
);
    logic               s1, s2, sig;
    logic [NOISE_W-1:0] run;
    logic [NOISE_W:0]   run_nxt;

    assign sig     = s2 ^ pol;
    assign run_nxt = {1'b0, run} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
        end else begin
            s1 <= ir_in;
            s2 <= s1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            filt <= 1'b0;
            run  <= '0;
        end else if (tick) begin
            if (sig != filt) begin
                if (run_nxt >= {1'b0, noise}) begin
                    filt <= sig;
                    run  <= '0;
                end else begin
                    run <= run_nxt[NOISE_W-1:0];
                end
            end else begin
                run <= '0;
            end
        end
    end
endmodule

// File: rtl/ir_symcap_timer.sv
module ir_symcap_timer
    import ir_symcap_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             en,
    input  logic             filt,
    input  logic [SYM_W-1:0] maxper,
    output logic             push_v,
    output sym_t             push_d
);
    logic             filt_q, active, mark_done;
    logic [SYM_W:0]   cnt, nxt;
    logic [SYM_W-1:0] mark;
    logic             rise, fall, over;
    logic [SYM_W-1:0] mark_now;

    assign rise     = filt & ~filt_q;
    assign fall     = ~filt & filt_q;
    assign nxt      = cnt + 1'b1;
    assign over     = nxt > {1'b0, maxper};
    assign mark_now = mark_done ? mark : sat_count(nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            filt_q    <= 1'b0;
            active    <= 1'b0;
            mark_done <= 1'b0;
            cnt       <= '0;
            mark      <= '0;
            push_v    <= 1'b0;
            push_d    <= '0;
        end else begin
            push_v <= 1'b0;
            if (tick) begin
                filt_q <= filt;
                if (!en) begin
                    active <= 1'b0;
                end else if (!active) begin
                    if (rise) begin
                        active    <= 1'b1;
                        cnt       <= '0;
                        mark_done <= 1'b0;
                    end
                end else if (rise) begin
                    push_v        <= 1'b1;
                    push_d.mark   <= mark_now;
                    push_d.period <= over ? END_CODE : nxt[SYM_W-1:0];
                    cnt           <= '0;
                    mark_done     <= 1'b0;
                end else if (over) begin
                    push_v        <= 1'b1;
                    push_d.mark   <= mark_now;
                    push_d.period <= END_CODE;
                    active        <= 1'b0;
                end else if (fall) begin
                    mark      <= sat_count(nxt);
                    mark_done <= 1'b1;
                    cnt       <= nxt;
                end else begin
                    cnt <= nxt;
                end
            end
        end
    end
endmodule

// File: rtl/ir_symcap_fifo.sv
module ir_symcap_fifo
    import ir_symcap_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        push,
    input  sym_t        din,
    input  logic        pop,
    output sym_t        dout,
    output logic        empty,
    output logic        full,
    output logic        accept,
    output logic        drop,
    output logic [AW:0] fill
);
    sym_t          mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          pop_ok;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty  = (fill == '0);
    assign full   = (fill == (AW+1)'(DEPTH));
    assign pop_ok = pop & ~empty;
    assign accept = push & (~full | pop_ok);
    assign drop   = push & ~accept;
    assign dout   = mem[rp];

    always_ff @(posedge clk) begin
        if (accept) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (accept) wp <= bump(wp);
            if (pop_ok) rp <= bump(rp);
            case ({accept, pop_ok})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/ir_symcap.sv
module ir_symcap
    import ir_symcap_pkg::*;
#(
    parameter int          DEPTH      = 8,
    parameter int          DIV_W      = 8,
    parameter int          DEF_DIV    = 10,
    parameter int          NOISE_W    = 8,
    parameter logic [15:0] DEF_MAXPER = 16'h5000,
    localparam int         AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        ir_in,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        irq
);
    logic               en_q, pol_q;
    logic [3:0]         ien_q, pend_q, set_ev, clr;
    logic [SYM_W-1:0]   maxper_q;
    logic [NOISE_W-1:0] noise_q;
    logic [DIV_W-1:0]   div_q;
    logic               tick, filt, push_v;
    sym_t               push_d, head;
    logic               empty, full, accept, drop, pop, pop_ok, wr, rd;
    logic [AW:0]        fill;

    assign wr     = bus_sel & bus_wr;
    assign rd     = bus_sel & ~bus_wr;
    assign pop    = rd && (bus_addr == REG_MARK);
    assign pop_ok = pop & ~empty;
    assign clr    = (wr && bus_addr == REG_CLEAR) ? bus_wdata[3:0] : 4'b0;

    ir_symcap_tick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst(rst), .div(div_q), .tick(tick)
    );

    ir_symcap_front #(.NOISE_W(NOISE_W)) u_front (
        .clk(clk), .rst(rst), .tick(tick), .ir_in(ir_in),
        .pol(pol_q), .noise(noise_q), .filt(filt)
    );

    ir_symcap_timer u_timer (
        .clk(clk), .rst(rst), .tick(tick), .en(en_q), .filt(filt),
        .maxper(maxper_q), .push_v(push_v), .push_d(push_d)
    );

    ir_symcap_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push_v), .din(push_d), .pop(pop),
        .dout(head), .empty(empty), .full(full), .accept(accept),
        .drop(drop), .fill(fill)
    );

    always_comb begin
        set_ev          = 4'b0;
        set_ev[EV_DATA] = accept;
        set_ev[EV_LAST] = accept && (push_d.period == END_CODE);
        set_ev[EV_OVR]  = drop;
        set_ev[EV_FULL] = accept && !pop_ok && (fill == (AW+1)'(DEPTH - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            pol_q    <= 1'b0;
            ien_q    <= 4'b0;
            pend_q   <= 4'b0;
            maxper_q <= DEF_MAXPER;
            noise_q  <= '0;
            div_q    <= DIV_W'(DEF_DIV);
        end else begin
            pend_q <= (pend_q & ~clr) | set_ev;
            if (wr) begin
                case (bus_addr)
                    REG_CTRL:   en_q     <= bus_wdata[0];
                    REG_POL:    pol_q    <= bus_wdata[0];
                    REG_IEN:    ien_q    <= bus_wdata[3:0];
                    REG_MAXPER: maxper_q <= bus_wdata;
                    REG_NOISE:  noise_q  <= bus_wdata[NOISE_W-1:0];
                    REG_DIV:    div_q    <= bus_wdata[DIV_W-1:0];
                    default:    ;
                endcase
            end
        end
    end

    assign irq = |(pend_q & ien_q);

    always_comb begin
        case (bus_addr)
            REG_PERIOD: bus_rdata = empty ? 16'h0 : head.period;
            REG_MARK:   bus_rdata = empty ? 16'h0 : head.mark;
            REG_IEN:    bus_rdata = {12'h0, ien_q};
            REG_PEND:   bus_rdata = {12'h0, pend_q};
            REG_CTRL:   bus_rdata = {15'h0, en_q};
            REG_MAXPER: bus_rdata = maxper_q;
            REG_NOISE:  bus_rdata = 16'(noise_q);
            REG_POL:    bus_rdata = {15'h0, pol_q};
            REG_STATUS: bus_rdata = {empty ? 8'h00 : 8'hFF, 5'b0, pend_q[EV_OVR], 2'b0};
            REG_DIV:    bus_rdata = 16'(div_q);
            default:    bus_rdata = 16'h0;
        endcase
    end
endmodule

// File: rtl/ir_symcap_chk.sv
module ir_symcap_chk #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic        clk,
    input logic        rst,
    input logic        en,
    input logic        push_v,
    input logic [15:0] period,
    input logic [15:0] maxper,
    input logic [AW:0] fill,
    input logic        pop,
    input logic [3:0]  pend,
    input logic        clr_ovr
);
    // R7: the queue never holds more than its depth
    p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
        fill <= (AW+1)'(DEPTH));

    // R7: a push into a full queue without a pop raises overrun
    p_drop_flags_r7: assert property (@(posedge clk) disable iff (rst)
        (push_v && fill == (AW+1)'(DEPTH) && !pop) |=> pend[2]);

    // R6: no push while capture has been off for two cycles
    p_quiet_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!en && !$past(en)) |-> !push_v);

    // R2: a recorded period never exceeds the maximum unless it is the end code
    p_period_bound_r2: assert property (@(posedge clk) disable iff (rst)
        (push_v && period != 16'hFFFF) |-> (period <= maxper));

    // R8: the fill level drops only after a mark read
    p_pop_only_by_mark_r8: assert property (@(posedge clk) disable iff (rst)
        (fill < $past(fill)) |-> $past(pop));

    // R9: overrun pending leaves only through a clear write
    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(pend[2]) |-> $past(clr_ovr));
endmodule

bind ir_symcap ir_symcap_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .en(en_q), .push_v(push_v),
    .period(push_d.period), .maxper(maxper_q), .fill(fill),
    .pop(pop), .pend(pend_q), .clr_ovr(clr[2])
);

// File: tb/ir_symcap_bench.sv
module ir_symcap_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ir_in = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = 4'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic act = 1'b1;

    localparam logic [3:0] A_PER = 4'd0, A_MARK = 4'd1, A_IEN = 4'd2, A_PEND = 4'd3,
                           A_CTRL = 4'd4, A_MAX = 4'd5, A_CLR = 4'd6, A_NOISE = 4'd7,
                           A_POL = 4'd8, A_STAT = 4'd9, A_DIV = 4'd10;

    always #5 clk = ~clk;

    ir_symcap u_ir_symcap (
        .clk(clk), .rst(rst), .ir_in(ir_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string tag, input logic [15:0] actual, input logic [15:0] expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input string tag, input logic [3:0] a, input logic [15:0] e);
        logic [15:0] v;
        rd_reg(a, v);
        check(tag, v, e);
    endtask

    task automatic do_reset();
        act = 1'b1;
        ir_in = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic setup(input int div, input int maxp, input int noise);
        do_reset();
        wr_reg(A_DIV, 16'(div));
        wr_reg(A_MAX, 16'(maxp));
        wr_reg(A_NOISE, 16'(noise));
        wr_reg(A_CTRL, 16'h1);
    endtask

    // must be called at a falling edge
    task automatic send(input int h, input int l);
        ir_in = act;
        repeat (h) @(negedge clk);
        ir_in = ~act;
        repeat (l) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        expect_reg("R10 maxper", A_MAX, 16'h5000);
        expect_reg("R10 div", A_DIV, 16'd10);
        expect_reg("R10 status", A_STAT, 16'h0000);
        expect_reg("R10 pend", A_PEND, 16'h0000);
        expect_reg("R10 ctrl", A_CTRL, 16'h0000);
        check("R10 irq", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_capture();
        setup(1, 1000, 0);
        send(7, 13); send(20, 5); send(3, 30);
        ir_in = act;
        repeat (10) @(negedge clk);
        expect_reg("R1 period0", A_PER, 16'd20);
        expect_reg("R8 period reread no pop", A_PER, 16'd20);
        expect_reg("R1 mark0", A_MARK, 16'd7);
        expect_reg("R1 period1", A_PER, 16'd25);
        expect_reg("R1 mark1", A_MARK, 16'd20);
        expect_reg("R1 period2", A_PER, 16'd33);
        expect_reg("R1 mark2", A_MARK, 16'd3);
        expect_reg("R8 empty status", A_STAT, 16'h0000);
        expect_reg("R8 empty period", A_PER, 16'h0000);
    endtask

    task automatic t_timeout();
        setup(1, 50, 0);
        wr_reg(A_IEN, 16'h2);
        send(10, 40);
        send(10, 80);
        expect_reg("R2 boundary period", A_PER, 16'd50);
        expect_reg("R2 boundary mark", A_MARK, 16'd10);
        expect_reg("R2 end period", A_PER, 16'hFFFF);
        expect_reg("R2 end mark", A_MARK, 16'd10);
        check("R9 irq on last", {15'h0, irq}, 16'h1);
        expect_reg("R9 pend data+last", A_PEND, 16'h0003);
        wr_reg(A_CLR, 16'h2);
        #1 check("R9 irq after clear", {15'h0, irq}, 16'h0);
        expect_reg("R9 pend after clear", A_PEND, 16'h0001);
        wr_reg(A_IEN, 16'h1);
        #1 check("R9 irq data enabled", {15'h0, irq}, 16'h1);
        wr_reg(A_CLR, 16'hF);
        expect_reg("R9 pend all cleared", A_PEND, 16'h0000);
        check("R9 irq none", {15'h0, irq}, 16'h0);
    endtask

    task automatic t_div();
        setup(4, 1000, 0);
        send(40, 60); send(40, 60);
        ir_in = act;
        repeat (20) @(negedge clk);
        expect_reg("R3 period", A_PER, 16'd25);
        expect_reg("R3 mark", A_MARK, 16'd10);
    endtask

    task automatic t_pol();
        do_reset();
        wr_reg(A_POL, 16'h1);
        act = 1'b0;
        ir_in = 1'b1;
        repeat (6) @(negedge clk);
        wr_reg(A_DIV, 16'd1);
        wr_reg(A_MAX, 16'd1000);
        wr_reg(A_CTRL, 16'h1);
        send(12, 28); send(12, 10);
        expect_reg("R4 period", A_PER, 16'd40);
        expect_reg("R4 mark", A_MARK, 16'd12);
    endtask

    task automatic t_glitch();
        setup(1, 200, 5);
        send(3, 20);
        send(10, 30);
        send(10, 300);
        expect_reg("R5 period0", A_PER, 16'd40);
        expect_reg("R5 mark0", A_MARK, 16'd10);
        expect_reg("R5 period1", A_PER, 16'hFFFF);
        expect_reg("R5 mark1", A_MARK, 16'd10);
        expect_reg("R5 drained", A_STAT, 16'h0000);
    endtask

    task automatic t_enable();
        do_reset();
        wr_reg(A_DIV, 16'd1);
        wr_reg(A_MAX, 16'd1000);
        send(8, 8); send(8, 8); send(8, 8);
        repeat (10) @(negedge clk);
        expect_reg("R6 nothing pushed", A_STAT, 16'h0000);
        expect_reg("R6 no pending", A_PEND, 16'h0000);
    endtask

    task automatic t_overrun();
        setup(1, 1000, 0);
        wr_reg(A_IEN, 16'h4);
        for (int i = 0; i < 10; i++) send(5, 5);
        ir_in = act;
        repeat (10) @(negedge clk);
        expect_reg("R7 status full+ovr", A_STAT, 16'hFF04);
        expect_reg("R9 pend data+ovr+full", A_PEND, 16'h000D);
        check("R7 irq on overrun", {15'h0, irq}, 16'h1);
        for (int i = 0; i < 8; i++) expect_reg("R7 drain mark", A_MARK, 16'd5);
        expect_reg("R7 status empty ovr", A_STAT, 16'h0004);
        wr_reg(A_CLR, 16'h4);
        expect_reg("R7 status cleared", A_STAT, 16'h0000);
    endtask

    task automatic t_coincide();
        logic [15:0] v;
        setup(1, 1000, 0);
        for (int k = 1; k <= 9; k++) send(k + 2, 10);
        ir_in = act;
        repeat (4) @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_MARK;
        #1 check("R11 head mark at overlap", bus_rdata, 16'd3);
        @(negedge clk);
        bus_sel = 1'b0;
        expect_reg("R11 no overrun", A_STAT, 16'hFF00);
        for (int k = 2; k <= 8; k++) begin
            rd_reg(A_MARK, v);
            check("R11 older entry", v, 16'(k + 2));
        end
        expect_reg("R11 new entry period", A_PER, 16'd21);
        expect_reg("R11 new entry mark", A_MARK, 16'd11);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        t_reset();
        t_capture();
        t_timeout();
        t_div();
        t_pol();
        t_glitch();
        t_enable();
        t_overrun();
        t_coincide();
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule